// File: doc/BRIEF.md
# Two-Wire ADC Result Slave

This block is the serial front end of a multichannel 12-bit converter. A fast system clock oversamples the two bus lines. The block recognises bus framing, shifts bytes in and out, and acknowledges its own device address. It captures the channel and input-mode choices that a bus master writes, and answers reads with a formatted conversion code. The digitised channel values arrive on a flat parallel input. The block drives the data line only by pulling it low through an output enable, which an open-drain pad turns into the bus level.

A master writes control bytes to choose a channel and either single-ended or differential measurement, and to choose between straight-binary and two's-complement coding. It then issues a read. The code is frozen when the read address is acknowledged. It is returned as two bytes, MSB first, and the pair repeats for as long as the master keeps acknowledging.

Top module: `adc_i2c_slave`

## Requirements
- R1: After reset, and after a STOP (data rising while clock is high), the block is idle with the data line released. A START (data falling while clock is high) begins an address phase.
- R2: Bits are taken on the clock rising edge, MSB first. A first byte whose upper seven bits equal the DEV_ADDR parameter is acknowledged by holding data low for the whole ninth clock pulse. Bit 0 of that byte selects a read (1) or a write (0).
- R3: A first byte with any other address gets no acknowledge. The block drives nothing and changes no setting until the next START.
- R4: A written byte with bit 7 = 0 is a control byte. Bits 4:1 give the channel (the low log2(NCH) bits are used), and bit 0 selects single-ended (1) or differential (0). Every written byte after a matching address is acknowledged.
- R5: A written byte with bit 7 = 1 is a coding byte, and its bit 2 selects bipolar (1) or unipolar (0). Reset state: single-ended, channel 0, unipolar.
- R6: A read returns byte A = {4'b1111, code[11:8]} and then byte B = code[7:0]. The code is captured when the read address is acknowledged. If the master acknowledges byte B, byte A follows again.
- R7: In single-ended mode the code is the selected channel value, whatever the bipolar bit says.
- R8: In differential unipolar mode the positive input is the selected channel c and the negative input is channel c XOR 1. The code is positive minus negative, and a negative difference gives 0.
- R9: In differential bipolar mode the code is the 12-bit two's complement of the difference, saturated to the range -2048 to 2047.
- R10: After the master does not acknowledge a read byte, the data line stays released until the next START.
- R11: A repeated START without a STOP begins a new address phase, and settings written before it are kept.
- R12: The block changes its data drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| ch_data_i | input | NCH*RES_W | Channel values, channel 0 in the lowest bits |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
On every cycle, the checker confirms four things: the drive never changes while the synchronised clock is high, the line is released whenever the slave is idle or ignoring the bus, the acknowledge stays low through the whole high phase, and the four padding bits of byte A are ones. Only the bench scenarios can show the computed codes of the three coding modes, including clamping and saturation. The same holds for address rejection leaving the settings unchanged, the frozen code repeating after an acknowledge, and the repeated START keeping the written control state.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } bus_st_e;

  localparam int BYTE_W    = 8;
  localparam int KIND_BIT  = 7;  // 1: coding byte, 0: control byte
  localparam int BIP_BIT   = 2;
  localparam int CH_LSB    = 1;
  localparam int SGL_BIT   = 0;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
  parameter int NCH   = 4,
  parameter int RES_W = 12,
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic [NCH*RES_W-1:0] ch_flat,
  input  logic [IDX_W-1:0]     sel,
  input  logic                 sgl,
  input  logic                 bip,
  output logic [RES_W-1:0]     code
);
  localparam logic signed [RES_W:0] POS_LIM = {2'b00, {(RES_W-1){1'b1}}};
  localparam logic signed [RES_W:0] NEG_LIM = {2'b11, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] ch [NCH];
  logic [RES_W-1:0] pos_v, neg_v;
  logic signed [RES_W:0] diff;

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign ch[g] = ch_flat[g*RES_W +: RES_W];
  end

  assign pos_v = ch[sel];
  assign neg_v = ch[sel ^ IDX_W'(1)];
  assign diff  = $signed({1'b0, pos_v}) - $signed({1'b0, neg_v});

  always_comb begin
    if (sgl)              code = pos_v;
    else if (!bip)        code = diff[RES_W] ? '0 : diff[RES_W-1:0];
    else if (diff > POS_LIM) code = POS_LIM[RES_W-1:0];
    else if (diff < NEG_LIM) code = NEG_LIM[RES_W-1:0];
    else                  code = diff[RES_W-1:0];
  end
endmodule

// File: rtl/adc_i2c_slave.sv
module adc_i2c_slave
  import adc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h35,
  parameter int         NCH         = 4,
  parameter int         RES_W       = 12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [NCH*RES_W-1:0] ch_data_i,
  output logic                 sda_oe_o
);
  localparam int IDX_W = $clog2(NCH);
  localparam int PAD_W = 2*BYTE_W - RES_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  bus_st_e state;
  logic [3:0] bitcnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic is_addr, rd_mode, byte_sel, mack;
  logic sgl_q, bip_q;
  logic [IDX_W-1:0] cs_q;
  logic [RES_W-1:0] snap_q, fmt_code;
  logic [BYTE_W-1:0] hi_byte, lo_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  adc_code_fmt #(.NCH(NCH), .RES_W(RES_W)) u_fmt (
    .ch_flat(ch_data_i), .sel(cs_q), .sgl(sgl_q), .bip(bip_q), .code(fmt_code)
  );

  assign hi_byte = {{PAD_W{1'b1}}, snap_q[RES_W-1:BYTE_W]};
  assign lo_byte = snap_q[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      is_addr  <= 1'b0;
      rd_mode  <= 1'b0;
      byte_sel <= 1'b0;
      mack     <= 1'b0;
      sgl_q    <= 1'b1;
      bip_q    <= 1'b0;
      cs_q     <= '0;
      snap_q   <= '0;
    end else if (start_det) begin
      state    <= ST_RX;
      bitcnt   <= '0;
      is_addr  <= 1'b1;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (is_addr) begin
              is_addr <= 1'b0;
              if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                sda_oe_o <= 1'b1;
                state    <= ST_RX_ACK;
                rd_mode  <= shreg[0];
                if (shreg[0]) snap_q <= fmt_code;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              if (shreg[KIND_BIT]) begin
                bip_q <= shreg[BIP_BIT];
              end else begin
                cs_q  <= shreg[CH_LSB +: IDX_W];
                sgl_q <= shreg[SGL_BIT];
              end
              sda_oe_o <= 1'b1;
              state    <= ST_RX_ACK;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              state    <= ST_TX;
              byte_sel <= 1'b0;
              txreg    <= hi_byte;
              sda_oe_o <= ~hi_byte[BYTE_W-1];
              bitcnt   <= '0;
            end else begin
              state    <= ST_RX;
              sda_oe_o <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              state    <= ST_TX_ACK;
            end else begin
              sda_oe_o <= ~txreg[BYTE_W-2];
              txreg    <= {txreg[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              byte_sel <= ~byte_sel;
              txreg    <= byte_sel ? hi_byte : lo_byte;
              sda_oe_o <= byte_sel ? ~hi_byte[BYTE_W-1] : ~lo_byte[BYTE_W-1];
              bitcnt   <= '0;
              state    <= ST_TX;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_i2c_slave_chk.sv
module adc_i2c_slave_chk
  import adc_i2c_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       sda_oe,
  input bus_st_e    state,
  input logic [3:0] bitcnt,
  input logic       byte_sel
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s)); // R12

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R1

  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe); // R10

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RX_ACK && scl_s) |-> sda_oe); // R2

  AST_PAD_ONES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX && !byte_sel && bitcnt < 4'd4 && scl_s) |-> !sda_oe); // R6
endmodule

bind adc_i2c_slave adc_i2c_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .state(state), .bitcnt(bitcnt), .byte_sel(byte_sel)
);

// File: tb/adc_i2c_slave_bench.sv
module adc_i2c_slave_bench;
  localparam logic [6:0] ADDR = 7'h35;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [11:0] chv [4];
  logic [47:0] ch_data;

  int tests = 0;
  int fails = 0;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      req_q[$];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign ch_data  = {chv[3], chv[2], chv[1], chv[0]};

  adc_i2c_slave u_adc_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .ch_data_i(ch_data), .sda_oe_o(sda_oe)
  );

  function automatic int model(int cs, bit sgl, bit bip);
    int p, n, d;
    p = int'(chv[cs % 4]);
    n = int'(chv[(cs % 4) ^ 1]);
    if (sgl) return p;
    d = p - n;
    if (!bip) return (d < 0) ? 0 : d;
    if (d > 2047) d = 2047;
    if (d < -2048) d = -2048;
    return d & 32'hFFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string r;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(r, int'(g), int'(e));
    end
  end

  task automatic wq(int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic bit_out(bit b);
    sda_m = b; wq();
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq();
  endtask

  task automatic bit_in(output bit b, output bit stable);
    logic s0;
    sda_m = 1'b1; wq();
    scl = 1'b1; wq(1);
    s0 = sda_line;
    wq(2*Q - 2);
    b = sda_line;
    stable = (s0 == b);
    wq(1);
    scl = 1'b0; wq();
  endtask

  task automatic wr_byte(logic [7:0] v, output bit acked);
    bit b, st;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b, st);
    acked = !b;
  endtask

  task automatic rd_byte(output logic [7:0] v, input bit master_ack, output bit stable);
    bit b, st;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b, st);
      v[i] = b;
      stable &= st;
    end
    bit_out(!master_ack);
  endtask

  function automatic logic [7:0] cfgb(int cs, bit sgl);
    return {3'b000, 4'(cs), sgl};
  endfunction

  function automatic logic [7:0] setb(bit bip);
    return 8'h80 | (8'(bip) << 2);
  endfunction

  task automatic write2(logic [7:0] a, logic [7:0] b);
    bit ack;
    bus_start();
    wr_byte({ADDR, 1'b0}, ack); chk("R2 write addr ack", ack, 1);
    wr_byte(a, ack);            chk("R4 byte ack", ack, 1);
    wr_byte(b, ack);            chk("R5 byte ack", ack, 1);
    bus_stop();
    wq(4);
    chk("R1 released after stop", sda_oe, 0);
  endtask

  // Read nbytes; last one NACKed, then one more byte must read all ones
  task automatic read_res(string req, int code, int nbytes, bit do_start = 1'b1);
    bit ack, st;
    logic [7:0] v;
    if (do_start) bus_start();
    wr_byte({ADDR, 1'b1}, ack); chk("R2 read addr ack", ack, 1);
    for (int i = 0; i < nbytes; i++) begin
      exp_q.push_back((i % 2 == 0) ? {4'hF, 4'(code >> 8)} : 8'(code));
      req_q.push_back(req);
      rd_byte(v, i != nbytes - 1, st);
      got_q.push_back(v);
      chk("R12 drive stable while clock high", st, 1);
    end
    rd_byte(v, 1'b0, st);
    chk("R10 released after master nack", v, 8'hFF);
    bus_stop();
  endtask

  initial begin
    repeat (3000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ack, st;
    logic [7:0] v;
    chv[0] = 12'h9A5; chv[1] = 12'h123; chv[2] = 12'hABC; chv[3] = 12'h40E;
    wq(10);
    chk("R1 reset release", sda_oe, 0);
    rst = 1'b0;
    wq(10);
    chk("R1 idle after reset", sda_oe, 0);

    // R5 reset defaults: single-ended ch0 unipolar
    read_res("R5", model(0, 1, 0), 2);

    // R3 wrong address, write attempted: no ack, no setting change
    bus_start();
    wr_byte({ADDR ^ 7'h01, 1'b0}, ack); chk("R3 no ack on mismatch", ack, 0);
    wr_byte(cfgb(2, 0), ack);           chk("R3 data ignored", ack, 0);
    bus_stop();
    read_res("R3", model(0, 1, 0), 2);

    // R3 wrong address read: line stays high
    bus_start();
    wr_byte({ADDR ^ 7'h40, 1'b1}, ack); chk("R3 no ack on read mismatch", ack, 0);
    rd_byte(v, 1'b1, st);               chk("R3 nothing driven", v, 8'hFF);
    bus_stop();

    // R4 + R6: single ch2, three bytes (A, B, A again)
    write2(setb(0), cfgb(2, 1));
    read_res("R6", model(2, 1, 0), 3);

    // R7: single-ended ignores bipolar
    write2(setb(1), cfgb(1, 1));
    read_res("R7", model(1, 1, 1), 2);

    // R8: differential unipolar positive and clamped
    write2(setb(0), cfgb(0, 0));
    read_res("R8", model(0, 0, 0), 2);
    write2(setb(0), cfgb(3, 0));
    read_res("R8", model(3, 0, 0), 2);

    // R9: bipolar small negative, positive and negative saturation
    chv[0] = 12'h100; chv[1] = 12'h180;
    write2(setb(1), cfgb(0, 0));
    read_res("R9", model(0, 0, 1), 2);
    chv[0] = 12'hFFF; chv[1] = 12'h000;
    read_res("R9", model(0, 0, 1), 2);
    write2(setb(1), cfgb(1, 0));
    read_res("R9", model(1, 0, 1), 2);

    // R11: write control then repeated START into a read
    bus_start();
    wr_byte({ADDR, 1'b0}, ack); chk("R11 write addr ack", ack, 1);
    wr_byte(cfgb(3, 1), ack);   chk("R11 control ack", ack, 1);
    bus_start();
    read_res("R11", model(3, 1, 1), 2, 1'b0);

    wq(20);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule